// File: doc/BRIEF.md
# Pipeline Hazard Forwarding and Stall Unit

This block is the hazard-control logic of a five-stage in-order pipeline. It does not contain the ALU or the register file. It watches the two source register numbers of the instruction in decode, which sits in the IF/ID register. It also watches what the two instructions ahead of it will write: the ID/EX register's destination, write-enable and load flag, and the EX/MEM register's destination and write-enable. From these it decides three things. The first is where each ALU operand of that instruction must come from once it reaches EX. The second is whether the instruction must be held for one cycle because it consumes a load result that is not ready yet. The third is whether the young instructions must be discarded because a branch in EX has resolved taken.

Branches are handled predict-not-taken. Fetch runs on sequentially, and when the branch condition in EX comes out true, the flush output clears IF/ID and ID/EX to no-ops. The operand selects are decided one cycle early and held in registers, so they are ready when the instruction enters EX. In that cycle the producer that was one slot ahead has moved to EX/MEM, and the producer that was two slots ahead has moved to MEM/WB. Only ALU results can be forwarded. A load followed at once by an instruction that reads its destination costs one bubble. After that bubble, the loaded value is forwarded from the write-back stage.

Top module: `hazard_ctl`

## Requirements
- R1: A synchronous active-high reset sets both operand selects to 00 (register file) at the first clock edge where reset is high.
- R2: `stall` is high, within the same cycle, when the ID/EX instruction is a load with write-enable set and a non-zero destination that equals either decode source register, and `flush` is low.
- R3: `flush` follows `br_taken` in the same cycle, and a high `flush` forces `stall` low.
- R4: Operand select codes are 2 bits: 00 = register file, 01 = MEM/WB write-back value, 10 = EX/MEM ALU result. The code 11 never appears.
- R5: When a non-load ID/EX instruction with write-enable set and a non-zero destination matches a decode source, that operand's select is 10 after the next clock edge.
- R6: When an EX/MEM instruction with write-enable set and a non-zero destination matches a decode source, that operand's select is 01 after the next clock edge. This holds for loads too.
- R7: When both the ID/EX instruction and the EX/MEM instruction match the same source, the select is 10.
- R8: A source of register 0 never forwards. A producer whose write-enable is clear causes neither a forward nor a stall. A destination of 0 causes neither.
- R9: After a stall cycle, both selects are 00, because EX holds a bubble.
- R10: After a flush cycle, both selects are 00.
- R11: A load in ID/EX never produces select 10. Each operand select is decided independently of the other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination held in ID/EX |
| ex_wen | input | 1 | Register write-enable held in ID/EX |
| ex_load | input | 1 | ID/EX instruction is a load |
| mem_rd | input | REG_W | Destination held in EX/MEM |
| mem_wen | input | 1 | Register write-enable held in EX/MEM |
| br_taken | input | 1 | Branch in EX resolved taken |
| fwd_a | output | 2 | Operand A source select for the EX instruction |
| fwd_b | output | 2 | Operand B source select for the EX instruction |
| stall | output | 1 | Freeze PC and IF/ID and insert a bubble into ID/EX |
| flush | output | 1 | Clear IF/ID and ID/EX to no-ops |

## Verification
`stall` and `flush` are combinational, so a wrong decode comparison shows at the ports in the same cycle. The select registers add one cycle: a wrong priority, a missed zero-register check or a lost bubble only shows on `fwd_a` or `fwd_b` after the following edge. The bench therefore checks the control outputs before the edge and the selects after it. The load-use case is followed across two cycles: first the bubble, then the forward from write-back.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_ALU = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/hazard_src_fwd.sv
module hazard_src_fwd
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] near_rd,
  input  logic             near_wen,
  input  logic             near_load,
  input  logic [REG_W-1:0] far_rd,
  input  logic             far_wen,
  output opnd_sel_e        sel_nxt
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic near_hit;
  logic far_hit;

  // Producer one slot ahead will sit in EX/MEM; only ALU results qualify.
  assign near_hit = near_wen && !near_load && (near_rd != ZERO_REG) && (near_rd == src);
  // Producer two slots ahead will sit in MEM/WB; loads qualify there.
  assign far_hit  = far_wen && (far_rd != ZERO_REG) && (far_rd == src);

  always_comb begin
    if (near_hit)     sel_nxt = SEL_ALU;
    else if (far_hit) sel_nxt = SEL_WB;
    else              sel_nxt = SEL_RF;
  end
endmodule

// File: rtl/hazard_load_use.sv
module hazard_load_use #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic [REG_W-1:0]           ld_rd,
  input  logic                       ld_wen,
  input  logic                       ld_is_load,
  output logic                       hold
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = (srcs[i] == ld_rd);
  end

  assign hold = ld_is_load && ld_wen && (ld_rd != ZERO_REG) && (|hit);
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             br_taken,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             flush
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  opnd_sel_e                  sel_nxt [NSRC];
  opnd_sel_e                  sel_q   [NSRC];
  logic                       hold_raw;
  logic                       bubble;

  assign srcs[0] = id_rs1;
  assign srcs[1] = id_rs2;

  hazard_load_use #(.REG_W(REG_W), .NSRC(NSRC)) u_load_use (
    .srcs       (srcs),
    .ld_rd      (ex_rd),
    .ld_wen     (ex_wen),
    .ld_is_load (ex_load),
    .hold       (hold_raw)
  );

  assign flush  = br_taken;
  assign stall  = hold_raw && !br_taken;
  // A bubble or no-op enters EX at the next edge.
  assign bubble = stall || flush;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hazard_src_fwd #(.REG_W(REG_W)) u_fwd (
      .src       (srcs[i]),
      .near_rd   (ex_rd),
      .near_wen  (ex_wen),
      .near_load (ex_load),
      .far_rd    (mem_rd),
      .far_wen   (mem_wen),
      .sel_nxt   (sel_nxt[i])
    );

    always_ff @(posedge clk) begin
      if (rst)         sel_q[i] <= SEL_RF;
      else if (bubble) sel_q[i] <= SEL_RF;
      else             sel_q[i] <= sel_nxt[i];
    end
  end

  assign fwd_a = sel_q[0];
  assign fwd_b = sel_q[1];
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic             ex_load,
  input logic             br_taken,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             stall,
  input logic             flush
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r4_sel_legal: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  a_r2_stall_cause: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_load && ex_wen && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)));

  a_r3_flush_wins: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (flush && !stall));

  a_r9_bubble_clear: assert property (@(posedge clk) disable iff (rst)
    stall |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r10_flush_clear: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r8_zero_src: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0) |=> (fwd_a == 2'b00));

  a_r11_load_no_alu: assert property (@(posedge clk) disable iff (rst)
    (ex_load && id_rs2 == ex_rd) |=> (fwd_b != 2'b10));
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .id_rs1   (id_rs1),
  .id_rs2   (id_rs2),
  .ex_rd    (ex_rd),
  .ex_wen   (ex_wen),
  .ex_load  (ex_load),
  .br_taken (br_taken),
  .fwd_a    (fwd_a),
  .fwd_b    (fwd_b),
  .stall    (stall),
  .flush    (flush)
);

// File: tb/hazard_ctl_test.sv
module hazard_ctl_test;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic          ex_wen, ex_load, mem_wen, br_taken;
  logic [1:0]    fwd_a, fwd_b;
  logic          stall, flush;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hazard_ctl #(.REG_W(RW)) uut (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .br_taken(br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .flush(flush)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [RW-1:0] s1, s2, erd, input logic ew, el,
                       input logic [RW-1:0] mrd, input logic mw, bt);
    id_rs1 = s1; id_rs2 = s2; ex_rd = erd; ex_wen = ew; ex_load = el;
    mem_rd = mrd; mem_wen = mw; br_taken = bt;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(5'd3, 5'd3, 5'd3, 1'b1, 1'b0, 5'd3, 1'b1, 1'b0);
    tick();
    chk("R1 fwd_a", fwd_a, 2'b00);
    chk("R1 fwd_b", fwd_b, 2'b00);
    rst = 1'b0;
  endtask

  task automatic t_alu_fwd();
    drive(5'd5, 5'd7, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0);
    chk("R5 no stall", {1'b0, stall}, 2'b00);
    tick();
    chk("R5 fwd_a", fwd_a, 2'b10);
    chk("R11 fwd_b independent", fwd_b, 2'b00);
  endtask

  task automatic t_wb_fwd();
    drive(5'd1, 5'd9, 5'd2, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0);
    tick();
    chk("R6 fwd_a", fwd_a, 2'b00);
    chk("R6 fwd_b", fwd_b, 2'b01);
  endtask

  task automatic t_priority();
    drive(5'd4, 5'd4, 5'd4, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0);
    tick();
    chk("R7 fwd_a", fwd_a, 2'b10);
    chk("R7 fwd_b", fwd_b, 2'b10);
  endtask

  task automatic t_zero_and_wen();
    drive(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0);
    tick();
    chk("R8 r0 fwd_a", fwd_a, 2'b00);
    chk("R8 r0 fwd_b", fwd_b, 2'b00);
    drive(5'd6, 5'd8, 5'd6, 1'b0, 1'b1, 5'd8, 1'b0, 1'b0);
    chk("R8 wen clear no stall", {1'b0, stall}, 2'b00);
    tick();
    chk("R8 wen clear fwd_a", fwd_a, 2'b00);
    chk("R8 wen clear fwd_b", fwd_b, 2'b00);
    drive(5'd0, 5'd2, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0);
    chk("R8 load to r0 no stall", {1'b0, stall}, 2'b00);
    tick();
  endtask

  task automatic t_load_use();
    // Load to r6 in ID/EX; decode reads r3 (matches EX/MEM) and r6.
    drive(5'd3, 5'd6, 5'd6, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0);
    chk("R2 stall", {1'b0, stall}, 2'b01);
    chk("R3 no flush", {1'b0, flush}, 2'b00);
    tick();
    chk("R9 bubble fwd_a", fwd_a, 2'b00);
    chk("R9 bubble fwd_b", fwd_b, 2'b00);
    // Bubble in ID/EX, load now in EX/MEM; held instruction retries.
    drive(5'd3, 5'd6, 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 1'b0);
    chk("R2 stall released", {1'b0, stall}, 2'b00);
    tick();
    chk("R6 load value from write-back", fwd_b, 2'b01);
    chk("R11 fwd_a independent", fwd_a, 2'b00);
  endtask

  task automatic t_load_no_alu();
    drive(5'd12, 5'd13, 5'd12, 1'b1, 1'b1, 5'd12, 1'b1, 1'b1);
    chk("R3 flush", {1'b0, flush}, 2'b01);
    chk("R3 flush overrides stall", {1'b0, stall}, 2'b00);
    tick();
    chk("R10 flush fwd_a", fwd_a, 2'b00);
    drive(5'd12, 5'd13, 5'd13, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1);
    tick();
    chk("R10 flush blocks alu forward", fwd_b, 2'b00);
    drive(5'd20, 5'd21, 5'd21, 1'b1, 1'b1, 5'd20, 1'b1, 1'b0);
    chk("R2 stall on rs2", {1'b0, stall}, 2'b01);
    tick();
    chk("R11 load never gives 10", fwd_b, 2'b00);
  endtask

  initial begin
    rst = 1'b1;
    drive('0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    @(negedge clk);
    t_reset();
    chk("R3 flush idle", {1'b0, flush}, 2'b00);
    t_alu_fwd();
    t_wb_fwd();
    t_priority();
    t_zero_and_wen();
    t_load_use();
    t_load_no_alu();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule